// File: doc/BRIEF.md
# Tagged Fully-Associative Micro Translation Cache

This block is a ten-entry translation cache that sits in front of a larger translation store. It turns a 48-bit virtual address into a 40-bit physical address plus an opaque attribute byte. Every entry carries a virtual machine tag, an address-space tag and a global flag. Switching address space or virtual machine therefore only changes the lookup inputs and never forces a flush. Each entry is either a 4KB page or a 64KB page. The page size sets how many virtual-address bits take part in the compare and how many offset bits pass straight through to the physical address.

Lookup is purely combinational and always answers in the same cycle, so it has no ready signal: `lk_valid` only qualifies the request, and `lk_hit`, `lk_pa` and `lk_attr` are zero when it is low or when nothing matches. After a miss, the translation walker writes the result through the fill stream (`fill_valid`/`fill_ready`). A fill is taken on a clock edge where both are high. The maintenance port (`inv_valid`) completes an invalidation in one cycle and never stalls. It applies back-pressure to the fill stream: `fill_ready` is low whenever `inv_valid` is high, and a stalled fill must hold its payload until it is accepted. Fill and invalidate results become visible to lookups after the next rising clock edge.

Top module: `tagged_utlb`

## Requirements
- R1: The cache holds 10 entries, all compared in parallel; ten fills of distinct pages into an empty cache all remain resident and hit.
- R2: With `lk_mode64`=1 the full 16-bit stored and current address-space tags must be equal; with `lk_mode64`=0 only bits [7:0] are compared and bits [15:8] are ignored.
- R3: A 4KB entry (`fill_big`=0) matches on VA[47:12] and returns {stored PA[39:12], VA[11:0]}; a 64KB entry (`fill_big`=1) matches on VA[47:16] and returns {stored PA[39:16], VA[15:0]}.
- R4: An entry filled with `fill_global`=1 hits whatever the current address-space tag is.
- R5: A hit requires the stored virtual machine tag to equal `lk_vmid`; entries for the same page under different machine tags coexist and return their own translations.
- R6: Entries are written only by accepted fills and become visible at the next clock edge; lookups, hits and misses never change the contents.
- R7: A fill with `fill_mode64`=0 and `fill_big`=1 is accepted but discarded; the contents are unchanged.
- R8: An accepted fill goes to the lowest-numbered invalid entry; if none is invalid, it goes to a round-robin pointer that starts at 0 after reset, advances by one on every accepted fill (discarded ones excluded) and wraps from 9 to 0.
- R9: `inv_kind`=0 invalidates every entry.
- R10: `inv_kind`=1 invalidates non-global entries whose tag equals `inv_asid` (16 bits when `inv_mode64`=1, bits [7:0] otherwise); global entries survive.
- R11: `inv_kind`=2 invalidates every entry whose machine tag equals `inv_vmid`.
- R12: `inv_kind`=3 invalidates every entry whose page, at its own granule, contains `inv_va`.
- R13: `fill_ready` is low while `inv_valid` is high, and a fill offered in that cycle has no effect.
- R14: No fill creates two entries that can match one lookup: resident entries with the same machine tag, an overlapping page (compared at the coarser of the two granules) and a clashing context (either global, or tags equal in bits [7:0]) are removed, and the fill lands in the lowest of them. If several entries still match, the lowest index supplies the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, empties the cache |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space tag |
| lk_vmid | input | 8 | Current virtual machine tag |
| lk_mode64 | input | 1 | 1: 64-bit mode (wide tag compare), 0: 32-bit mode |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_pa | output | 40 | Translated physical address, zero on miss |
| lk_attr | output | 8 | Opaque attributes of the matching entry, zero on miss |
| fill_valid | input | 1 | Fill payload present |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_va | input | 48 | Virtual address of the filled page |
| fill_pa | input | 40 | Physical address of the filled page |
| fill_attr | input | 8 | Attributes to store |
| fill_asid | input | 16 | Address-space tag to store |
| fill_vmid | input | 8 | Machine tag to store |
| fill_global | input | 1 | Entry ignores the address-space tag |
| fill_big | input | 1 | 1: 64KB page, 0: 4KB page |
| fill_mode64 | input | 1 | Mode in force when the walk ran |
| inv_valid | input | 1 | Invalidate request, completes in one cycle |
| inv_kind | input | 2 | 0 all, 1 by address-space tag, 2 by machine tag, 3 by address |
| inv_va | input | 48 | Address for kind 3 |
| inv_asid | input | 16 | Tag for kind 1 |
| inv_vmid | input | 8 | Machine tag for kind 2 |
| inv_mode64 | input | 1 | Tag width for kind 1 |

## Verification
Directed lookups vary one tag at a time against a known resident entry: address-space tags that differ only in their upper byte separate the two mode widths, and a global entry probed with unrelated tags shows the global bypass. The same page under two machine tags shows that the tags stay separate. Offsets inside a 64KB page that a 4KB compare would reject separate the granules. An ordered run of fills past capacity, with a hole punched by an address invalidate, shows where each fill lands by which earlier pages then miss. A long stretch of random traffic over a small page, tag and granule space forces overlapping fills, invalidates that collide with fills, and discarded fills. There, a behavioural model compared every cycle catches any duplicate match or wrong victim.

// File: rtl/tagged_utlb_pkg.sv
package tagged_utlb_pkg;
  localparam int VA_W        = 48;
  localparam int PA_W        = 40;
  localparam int ASID_W      = 16;
  localparam int ASID_NARROW = 8;
  localparam int VMID_W      = 8;
  localparam int ATTR_W      = 8;
  localparam int SMALL_SH    = 12;
  localparam int LARGE_SH    = 16;
  localparam int BIG_DROP    = LARGE_SH - SMALL_SH;
  localparam int VPN_W       = VA_W - SMALL_SH;
  localparam int PPN_W       = PA_W - SMALL_SH;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_VMID = 2'd2,
    INV_VA   = 2'd3
  } inv_kind_e;

  typedef struct packed {
    logic               vld;
    logic               glob;
    logic               big;
    logic [ASID_W-1:0]  asid;
    logic [VMID_W-1:0]  vmid;
    logic [VPN_W-1:0]   vpn;
    logic [PPN_W-1:0]   ppn;
    logic [ATTR_W-1:0]  attr;
  } tlb_ent_t;

  function automatic logic asid_eq(input logic [ASID_W-1:0] a,
                                   input logic [ASID_W-1:0] b,
                                   input logic wide);
    if (wide) return a == b;
    return a[ASID_NARROW-1:0] == b[ASID_NARROW-1:0];
  endfunction

  function automatic logic page_hit(input logic [VPN_W-1:0] vpn,
                                    input logic big,
                                    input logic [VPN_W-1:0] page);
    if (big) return vpn[VPN_W-1:BIG_DROP] == page[VPN_W-1:BIG_DROP];
    return vpn == page;
  endfunction

  function automatic logic [PA_W-1:0] form_pa(input tlb_ent_t e,
                                              input logic [VA_W-1:0] va);
    if (e.big) return {e.ppn[PPN_W-1:BIG_DROP], va[LARGE_SH-1:0]};
    return {e.ppn, va[SMALL_SH-1:0]};
  endfunction
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
  import tagged_utlb_pkg::*;
#(
  parameter int ENTRIES = 10
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VPN_W-1:0]       page,
  input  logic [ASID_W-1:0]      asid,
  input  logic [VMID_W-1:0]      vmid,
  input  logic                   mode64,
  output logic [ENTRIES-1:0]     hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic ctx_ok;
    logic vm_ok;
    logic pg_ok;
    assign ctx_ok = ents[i].glob || asid_eq(ents[i].asid, asid, mode64);
    assign vm_ok  = ents[i].vmid == vmid;
    assign pg_ok  = page_hit(ents[i].vpn, ents[i].big, page);
    assign hit_vec[i] = ents[i].vld && vm_ok && ctx_ok && pg_ok;
  end
endmodule

// File: rtl/utlb_read.sv
module utlb_read
  import tagged_utlb_pkg::*;
#(
  parameter int ENTRIES = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [ENTRIES-1:0]     hit_vec,
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VA_W-1:0]        va,
  output logic                   hit,
  output logic [PA_W-1:0]        pa,
  output logic [ATTR_W-1:0]      attr
);
  always_comb begin
    hit  = 1'b0;
    pa   = '0;
    attr = '0;
    if (req) begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (hit_vec[i]) begin
          hit  = 1'b1;
          pa   = form_pa(ents[i], va);
          attr = ents[i].attr;
        end
      end
    end
  end

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[SMALL_SH-1:0] == va[SMALL_SH-1:0]);

  // R14
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/utlb_alloc.sv
module utlb_alloc
  import tagged_utlb_pkg::*;
#(
  parameter int ENTRIES = 10,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic                   take,
  input  logic [VPN_W-1:0]       f_page,
  input  logic [ASID_W-1:0]      f_asid,
  input  logic [VMID_W-1:0]      f_vmid,
  input  logic                   f_glob,
  input  logic                   f_big,
  output logic [ENTRIES-1:0]     wr_vec,
  output logic [ENTRIES-1:0]     clr_vec
);
  logic [ENTRIES-1:0] clash;
  logic [ENTRIES-1:0] free;
  logic [IDX_W-1:0]   rr;
  logic [IDX_W-1:0]   clash_idx;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   tgt;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_scan
    logic ctx_clash;
    logic overlap;
    assign ctx_clash = ents[i].glob || f_glob ||
                       asid_eq(ents[i].asid, f_asid, 1'b0);
    assign overlap   = page_hit(ents[i].vpn, ents[i].big || f_big, f_page);
    assign clash[i]  = ents[i].vld && (ents[i].vmid == f_vmid) &&
                       ctx_clash && overlap;
    assign free[i]   = !ents[i].vld;
  end

  always_comb begin
    clash_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (clash[i]) clash_idx = IDX_W'(i);
      if (free[i])  free_idx  = IDX_W'(i);
    end
    if (|clash)     tgt = clash_idx;
    else if (|free) tgt = free_idx;
    else            tgt = rr;
  end

  always_comb begin
    wr_vec = '0;
    if (take) wr_vec[tgt] = 1'b1;
    clr_vec = take ? clash : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rr <= '0;
    else if (take) begin
      if (rr == IDX_W'(ENTRIES - 1)) rr <= '0;
      else                           rr <= rr + 1'b1;
    end
  end

  // R8
  rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr < IDX_W'(ENTRIES));

  // R8
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rr));
endmodule

// File: rtl/tagged_utlb.sv
module tagged_utlb
  import tagged_utlb_pkg::*;
#(
  parameter int ENTRIES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [47:0]       lk_va,
  input  logic [15:0]       lk_asid,
  input  logic [7:0]        lk_vmid,
  input  logic              lk_mode64,
  output logic              lk_hit,
  output logic [39:0]       lk_pa,
  output logic [7:0]        lk_attr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [47:0]       fill_va,
  input  logic [39:0]       fill_pa,
  input  logic [7:0]        fill_attr,
  input  logic [15:0]       fill_asid,
  input  logic [7:0]        fill_vmid,
  input  logic              fill_global,
  input  logic              fill_big,
  input  logic              fill_mode64,
  input  logic              inv_valid,
  input  logic [1:0]        inv_kind,
  input  logic [47:0]       inv_va,
  input  logic [15:0]       inv_asid,
  input  logic [7:0]        inv_vmid,
  input  logic              inv_mode64
);
  tlb_ent_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0]     hit_vec;
  logic [ENTRIES-1:0]     wr_vec;
  logic [ENTRIES-1:0]     clr_vec;
  logic [ENTRIES-1:0]     drop;
  logic [ENTRIES-1:0]     vld_vec;
  logic                   fill_go;
  logic                   fill_ok;
  tlb_ent_t               new_ent;
  inv_kind_e              kind;
  logic                   unused_low;

  assign unused_low = ^{fill_pa[SMALL_SH-1:0], inv_va[SMALL_SH-1:0]};

  assign fill_ready = !inv_valid;
  assign fill_go    = fill_valid && fill_ready;
  assign fill_ok    = fill_go && (fill_mode64 || !fill_big);
  assign kind       = inv_kind_e'(inv_kind);

  always_comb begin
    new_ent      = '0;
    new_ent.vld  = 1'b1;
    new_ent.glob = fill_global;
    new_ent.big  = fill_big;
    new_ent.asid = fill_asid;
    new_ent.vmid = fill_vmid;
    new_ent.vpn  = fill_va[VA_W-1:SMALL_SH];
    new_ent.ppn  = fill_pa[PA_W-1:SMALL_SH];
    new_ent.attr = fill_attr;
  end

  utlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .ents    (ents),
    .page    (lk_va[VA_W-1:SMALL_SH]),
    .asid    (lk_asid),
    .vmid    (lk_vmid),
    .mode64  (lk_mode64),
    .hit_vec (hit_vec)
  );

  utlb_read #(.ENTRIES(ENTRIES)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (lk_valid),
    .hit_vec (hit_vec),
    .ents    (ents),
    .va      (lk_va),
    .hit     (lk_hit),
    .pa      (lk_pa),
    .attr    (lk_attr)
  );

  utlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .ents    (ents),
    .take    (fill_ok),
    .f_page  (fill_va[VA_W-1:SMALL_SH]),
    .f_asid  (fill_asid),
    .f_vmid  (fill_vmid),
    .f_glob  (fill_global),
    .f_big   (fill_big),
    .wr_vec  (wr_vec),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ctl
    always_comb begin
      unique case (kind)
        INV_ALL:  drop[i] = 1'b1;
        INV_ASID: drop[i] = !ents[i].glob &&
                            asid_eq(ents[i].asid, inv_asid, inv_mode64);
        INV_VMID: drop[i] = ents[i].vmid == inv_vmid;
        INV_VA:   drop[i] = page_hit(ents[i].vpn, ents[i].big,
                                     inv_va[VA_W-1:SMALL_SH]);
        default:  drop[i] = 1'b0;
      endcase
    end

    assign vld_vec[i] = ents[i].vld;

    always_ff @(posedge clk) begin
      if (!rst_n)                     ents[i]     <= '0;
      else if (inv_valid && drop[i])  ents[i].vld <= 1'b0;
      else if (wr_vec[i])             ents[i]     <= new_ent;
      else if (clr_vec[i])            ents[i].vld <= 1'b0;
    end
  end

  // R9
  inv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_kind == 2'd0 |=> vld_vec == '0);

  // R7
  narrow_big_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !inv_valid && !fill_mode64 && fill_big |=> $stable(vld_vec));

  // R13
  inv_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> $countones(vld_vec) <= $past($countones(vld_vec)));

  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !inv_valid && (fill_mode64 || !fill_big) |=> vld_vec != '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid && !inv_valid |=> $stable(vld_vec));
endmodule

// File: tb/tagged_utlb_tb.sv
module tagged_utlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_mode64 = 1'b1;
  logic [47:0] lk_va = '0;
  logic [15:0] lk_asid = '0;
  logic [7:0]  lk_vmid = '0;
  logic        lk_hit;
  logic [39:0] lk_pa;
  logic [7:0]  lk_attr;
  logic        fill_valid = 1'b0, fill_ready;
  logic [47:0] fill_va = '0;
  logic [39:0] fill_pa = '0;
  logic [7:0]  fill_attr = '0, fill_vmid = '0;
  logic [15:0] fill_asid = '0;
  logic        fill_global = 1'b0, fill_big = 1'b0, fill_mode64 = 1'b1;
  logic        inv_valid = 1'b0, inv_mode64 = 1'b1;
  logic [1:0]  inv_kind = '0;
  logic [47:0] inv_va = '0;
  logic [15:0] inv_asid = '0;
  logic [7:0]  inv_vmid = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R6";

  // behavioural reference state
  bit          m_v[N], m_g[N], m_b[N];
  logic [15:0] m_asid[N];
  logic [7:0]  m_vmid[N], m_attr[N];
  logic [47:0] m_va[N];
  logic [39:0] m_pa[N];
  int          m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_utlb u_dut (.*);

  function automatic bit same_page(logic [47:0] a, logic [47:0] b, bit big);
    return big ? (a[47:16] == b[47:16]) : (a[47:12] == b[47:12]);
  endfunction

  function automatic bit tag_eq(logic [15:0] a, logic [15:0] b, bit wide);
    return wide ? (a == b) : (a[7:0] == b[7:0]);
  endfunction

  function automatic void m_look(output bit h, output logic [39:0] p, output logic [7:0] at);
    h = 0; p = '0; at = '0;
    if (!lk_valid) return;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_vmid[i] == lk_vmid && (m_g[i] || tag_eq(m_asid[i], lk_asid, lk_mode64))
          && same_page(m_va[i], lk_va, m_b[i])) begin
        h = 1;
        p = m_b[i] ? {m_pa[i][39:16], lk_va[15:0]} : {m_pa[i][39:12], lk_va[11:0]};
        at = m_attr[i];
        return;
      end
    end
  endfunction

  function automatic void m_edge();
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_rr = 0;
    end else if (inv_valid) begin
      for (int i = 0; i < N; i++) begin
        case (inv_kind)
          2'd0: m_v[i] = 0;
          2'd1: if (!m_g[i] && tag_eq(m_asid[i], inv_asid, inv_mode64)) m_v[i] = 0;
          2'd2: if (m_vmid[i] == inv_vmid) m_v[i] = 0;
          default: if (same_page(m_va[i], inv_va, m_b[i])) m_v[i] = 0;
        endcase
      end
    end else if (fill_valid && (fill_mode64 || !fill_big)) begin
      int t = -1;
      for (int i = 0; i < N; i++) begin
        if (m_v[i] && m_vmid[i] == fill_vmid && (m_g[i] || fill_global || m_asid[i][7:0] == fill_asid[7:0])
            && same_page(m_va[i], fill_va, m_b[i] || fill_big)) begin
          m_v[i] = 0;
          if (t < 0) t = i;
        end
      end
      if (t < 0) for (int i = 0; i < N; i++) if (!m_v[i] && t < 0) t = i;
      if (t < 0) t = m_rr;
      m_v[t] = 1; m_g[t] = fill_global; m_b[t] = fill_big; m_asid[t] = fill_asid;
      m_vmid[t] = fill_vmid; m_va[t] = fill_va; m_pa[t] = fill_pa; m_attr[t] = fill_attr;
      m_rr = (m_rr + 1) % N;
    end
  endfunction

  task automatic tick();
    bit h; logic [39:0] p; logic [7:0] at;
    #2;
    m_look(h, p, at);
    n_chk++;
    if (lk_hit !== h || lk_pa !== p || lk_attr !== at || fill_ready !== !inv_valid) begin
      n_fail++;
      $display("FAIL %s model: hit=%0b pa=%h attr=%h rdy=%0b exp hit=%0b pa=%h attr=%h rdy=%0b",
               cur_req, lk_hit, lk_pa, lk_attr, fill_ready, h, p, at, !inv_valid);
    end
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic look(logic [47:0] va, logic [15:0] asid, logic [7:0] vmid, bit m64,
                      bit eh, logic [39:0] ep, string tag);
    lk_valid = 1; lk_va = va; lk_asid = asid; lk_vmid = vmid; lk_mode64 = m64;
    #1;
    n_chk++;
    if (lk_hit !== eh || (eh && lk_pa !== ep)) begin
      n_fail++;
      $display("FAIL %s lookup va=%h: hit=%0b pa=%h exp hit=%0b pa=%h", tag, va, lk_hit, lk_pa, eh, ep);
    end
    tick();
  endtask

  task automatic fill(logic [47:0] va, logic [39:0] pa, logic [15:0] asid, logic [7:0] vmid,
                      bit g, bit big, bit m64);
    fill_valid = 1; fill_va = va; fill_pa = pa; fill_asid = asid; fill_vmid = vmid;
    fill_global = g; fill_big = big; fill_mode64 = m64; fill_attr = pa[19:12] ^ 8'h5a;
    tick();
    fill_valid = 0;
  endtask

  task automatic inv(logic [1:0] k, logic [15:0] asid, logic [7:0] vmid, logic [47:0] va, bit m64);
    inv_valid = 1; inv_kind = k; inv_asid = asid; inv_vmid = vmid; inv_va = va; inv_mode64 = m64;
    tick();
    inv_valid = 0;
  endtask

  function automatic logic [47:0] pg(int i);
    return 48'h10_0000_0000 + 48'(i) * 48'h1000;
  endfunction
  function automatic logic [39:0] pp(int i);
    return 40'h80_0000_0000 + 40'(i + 1) * 40'h1000;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    cur_req = "R6";
    look(pg(0), 16'h5, 8'h1, 1, 0, '0, "R6 empty after reset");

    // R1, R6: ten fills, same-cycle lookup misses, all resident
    cur_req = "R1";
    lk_valid = 1; lk_va = pg(0); lk_asid = 16'h5; lk_vmid = 8'h1; lk_mode64 = 1;
    fill_valid = 1; fill_va = pg(0); fill_pa = pp(0); fill_asid = 16'h5; fill_vmid = 8'h1;
    fill_global = 0; fill_big = 0; fill_mode64 = 1; fill_attr = 8'h11;
    #1; n_chk++;
    if (lk_hit !== 1'b0) begin n_fail++; $display("FAIL R6 fill visible early: hit=%0b exp 0", lk_hit); end
    tick(); fill_valid = 0;
    for (int i = 1; i < N; i++) fill(pg(i), pp(i), 16'h5, 8'h1, 0, 0, 1);
    for (int i = 0; i < N; i++) look(pg(i) | 48'h123, 16'h5, 8'h1, 1, 1, pp(i) | 40'h123, "R1 resident");

    // R8: round robin after full, first-invalid after a hole
    cur_req = "R8";
    fill(pg(10), pp(10), 16'h5, 8'h1, 0, 0, 1);
    look(pg(0), 16'h5, 8'h1, 1, 0, '0, "R8 rr evicts entry0");
    look(pg(10), 16'h5, 8'h1, 1, 1, pp(10), "R8 new page");
    fill(pg(11), pp(11), 16'h5, 8'h1, 0, 0, 1);
    look(pg(1), 16'h5, 8'h1, 1, 0, '0, "R8 rr evicts entry1");
    cur_req = "R12";
    inv(2'd3, '0, '0, pg(5) | 48'h7ff, 1);
    look(pg(5), 16'h5, 8'h1, 1, 0, '0, "R12 va invalidate");
    look(pg(6), 16'h5, 8'h1, 1, 1, pp(6), "R12 neighbour kept");
    cur_req = "R8";
    fill(pg(12), pp(12), 16'h5, 8'h1, 0, 0, 1);
    look(pg(2), 16'h5, 8'h1, 1, 1, pp(2), "R8 hole used, entry2 kept");
    fill(pg(13), pp(13), 16'h5, 8'h1, 0, 0, 1);
    look(pg(3), 16'h5, 8'h1, 1, 0, '0, "R8 rr resumes at entry3");
    look(pg(4), 16'h5, 8'h1, 1, 1, pp(4), "R8 entry4 kept");
    look(pg(12), 16'h5, 8'h1, 1, 1, pp(12), "R8 hole fill kept");

    // R9
    cur_req = "R9";
    inv(2'd0, '0, '0, '0, 1);
    for (int i = 2; i < 14; i += 3) look(pg(i), 16'h5, 8'h1, 1, 0, '0, "R9 all gone");

    // R2
    cur_req = "R2";
    fill(pg(20), pp(20), 16'h1234, 8'h1, 0, 0, 1);
    look(pg(20), 16'h5634, 8'h1, 1, 0, '0, "R2 wide tag differs");
    look(pg(20), 16'h5634, 8'h1, 0, 1, pp(20), "R2 narrow ignores upper byte");
    look(pg(20), 16'h1235, 8'h1, 0, 0, '0, "R2 narrow low byte differs");
    look(pg(20), 16'h1234, 8'h1, 1, 1, pp(20), "R2 wide equal");

    // R4
    cur_req = "R4";
    fill(pg(21), pp(21), 16'h0001, 8'h1, 1, 0, 1);
    look(pg(21), 16'h0099, 8'h1, 1, 1, pp(21), "R4 global any tag");

    // R5
    cur_req = "R5";
    look(pg(21), 16'h0001, 8'h2, 1, 0, '0, "R5 other vm misses");
    fill(pg(21), pp(30), 16'h0001, 8'h2, 1, 0, 1);
    look(pg(21), 16'h0001, 8'h2, 1, 1, pp(30), "R5 vm2 own pa");
    look(pg(21), 16'h0001, 8'h1, 1, 1, pp(21), "R5 vm1 kept");

    // R3
    cur_req = "R3";
    fill(48'h22_3456_0000, 40'h9a_bcde_0000, 16'h7, 8'h3, 0, 1, 1);
    look(48'h22_3456_abcd, 16'h7, 8'h3, 1, 1, 40'h9a_bcde_abcd, "R3 64KB offset");
    look(48'h22_3457_0000, 16'h7, 8'h3, 1, 0, '0, "R3 64KB boundary");
    fill(48'h22_5000_3000, 40'h11_2233_4000, 16'h7, 8'h3, 0, 0, 1);
    look(48'h22_5000_3fff, 16'h7, 8'h3, 1, 1, 40'h11_2233_4fff, "R3 4KB offset");
    look(48'h22_5000_4000, 16'h7, 8'h3, 1, 0, '0, "R3 4KB next page");

    // R7
    cur_req = "R7";
    fill(48'h33_0000_0000, 40'h12_0000_0000, 16'h7, 8'h3, 0, 1, 0);
    look(48'h33_0000_0000, 16'h7, 8'h3, 0, 0, '0, "R7 narrow 64KB discarded");

    // R14
    cur_req = "R14";
    fill(48'h22_3456_2000, 40'h44_0000_0000, 16'h7, 8'h3, 0, 0, 1);
    look(48'h22_3456_2010, 16'h7, 8'h3, 1, 1, 40'h44_0000_0010, "R14 4KB replaced 64KB");
    look(48'h22_3456_5000, 16'h7, 8'h3, 1, 0, '0, "R14 old 64KB gone");
    fill(48'h22_5000_0000, 40'h55_0000_0000, 16'h7, 8'h3, 0, 1, 1);
    look(48'h22_5000_3abc, 16'h7, 8'h3, 1, 1, 40'h55_0000_3abc, "R14 64KB covers old 4KB");

    // R10
    cur_req = "R10";
    fill(pg(40), pp(40), 16'h0207, 8'h4, 0, 0, 1);
    fill(pg(41), pp(41), 16'h0307, 8'h4, 1, 0, 1);
    fill(pg(42), pp(42), 16'h0008, 8'h4, 0, 0, 1);
    inv(2'd1, 16'h0107, '0, '0, 0);
    look(pg(40), 16'h0207, 8'h4, 1, 0, '0, "R10 narrow tag drop");
    look(pg(41), 16'h0307, 8'h4, 1, 1, pp(41), "R10 global survives");
    look(pg(42), 16'h0008, 8'h4, 1, 1, pp(42), "R10 other tag survives");

    // R11
    cur_req = "R11";
    inv(2'd2, '0, 8'h4, '0, 1);
    look(pg(42), 16'h0008, 8'h4, 1, 0, '0, "R11 vm drop");
    look(pg(21), 16'h0001, 8'h2, 1, 1, pp(30), "R11 other vm kept");

    // R13
    cur_req = "R13";
    inv_valid = 1; inv_kind = 2'd2; inv_vmid = 8'hee;
    fill_valid = 1; fill_va = pg(50); fill_pa = pp(50); fill_asid = 16'h5; fill_vmid = 8'h1;
    fill_global = 0; fill_big = 0; fill_mode64 = 1;
    #1; n_chk++;
    if (fill_ready !== 1'b0) begin n_fail++; $display("FAIL R13 fill_ready=%0b exp 0", fill_ready); end
    tick(); inv_valid = 0; fill_valid = 0;
    look(pg(50), 16'h5, 8'h1, 1, 0, '0, "R13 blocked fill absent");

    // random traffic against the model
    cur_req = "R14 random";
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom % 16;
      lk_valid = ($urandom % 8) != 0;
      lk_va = 48'h10_0000_0000 + 48'($urandom % 40) * 48'h1000 + 48'($urandom % 4096);
      lk_asid = ($urandom % 2) ? 16'h0101 : 16'h0201;
      lk_vmid = 8'($urandom % 2); lk_mode64 = $urandom % 2;
      fill_valid = r < 7; inv_valid = r == 7 || r == 8;
      fill_va = 48'h10_0000_0000 + 48'($urandom % 40) * 48'h1000;
      fill_pa = 40'($urandom) << 12; fill_attr = 8'($urandom);
      fill_asid = ($urandom % 2) ? 16'h0101 : 16'h0201;
      fill_vmid = 8'($urandom % 2); fill_global = ($urandom % 5) == 0;
      fill_big = ($urandom % 3) == 0; fill_mode64 = ($urandom % 4) != 0;
      inv_kind = 2'($urandom); inv_va = lk_va; inv_asid = lk_asid;
      inv_vmid = lk_vmid; inv_mode64 = $urandom % 2;
      if (r == 8) inv_kind = 2'd3;
      tick();
    end
    fill_valid = 0; inv_valid = 0;
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule